// File: doc/BRIEF.md
# Iterative SHA-1 Block Compression Engine

This block applies the SHA-1 compression function to a single 512-bit padded message block. It takes one clock per step for the 80 steps, plus one clock at the end to fold in the chaining value. The incoming 160-bit chaining value is either the fixed standard initial vector or a value driven on a port. A multi-block message is hashed by loading each block in turn and feeding each digest back as the chaining input of the next compression. Padding, length appending and message buffering are the job of the surrounding logic.

A block is written into an internal 16-word schedule ring with a load pulse. A start pulse captures the chaining value and begins the run. Load and start may arrive in the same cycle. The ring is rewritten with expanded schedule words during a run, so every compression needs a fresh load. While a run is in progress, `busy_o` is high. The result appears on `digest_o` together with a one-cycle `valid_o` pulse.

Top module: `sha1_step_core`

## Requirements
- R1: With `use_iv_i` high at an accepted start, the chaining value is 67452301 EFCDAB89 98BADCFE 10325476 C3D2E1F0. For the padded single block of "abc" (first word 61626380, last word 00000018, all others zero), the digest is a9993e364706816aba3e25717850c26c9cd0d89d.
- R2: With `use_iv_i` low at an accepted start, `chain_i` is the chaining value, and each result word is the compressed word plus the matching chaining word, modulo 2^32. Chaining the two padded blocks of the 56-character test message gives 84983e441c3bd26ebaae4aa1f95129e5e54670f1.
- R3: A `start_i` sampled while `busy_o` is low raises `busy_o` in the next cycle. A `start_i` sampled while `busy_o` is high is ignored.
- R4: `busy_o` stays high for exactly 81 consecutive cycles after an accepted start.
- R5: `valid_o` is high for exactly one cycle, which is the first cycle with `busy_o` low again. `digest_o` changes only at that point and holds its value until the next result.
- R6: `load_i` sampled while idle replaces the block. `load_i` sampled while busy is ignored and does not disturb the run in progress.
- R7: When `load_i` and `start_i` are sampled together while idle, the run uses the newly presented block.
- R8: Byte order is big-endian. `block_i[511:480]` is schedule word 0. `digest_o[159:128]` is the first result word, and `chain_i` uses the same layout.
- R9: Reset is synchronous and active high. After a clock edge with `rst` high, `busy_o`, `valid_o` and `digest_o` are zero, and any run in progress is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Write `block_i` into the schedule ring (idle only) |
| block_i | input | 512 | Padded message block, word 0 in the top bits |
| start_i | input | 1 | Begin a compression (idle only) |
| use_iv_i | input | 1 | 1: standard initial vector, 0: `chain_i` |
| chain_i | input | 160 | Supplied chaining value |
| busy_o | output | 1 | Compression in progress |
| valid_o | output | 1 | One-cycle pulse: `digest_o` holds a new result |
| digest_o | output | 160 | Updated chaining value |

## Verification
The bench builds the core with its default parameters: 80 steps, a 16-word schedule ring and 20 steps per round. Only these values keep the function identical to SHA-1, so the bench can check the output against the published test digests as well as a behavioural reference compression. The defaults bring every round boundary and the point where schedule expansion takes over at step 16 into each run. The reference model tracks busy, valid and digest on every clock. This lets start and load pulses during a run, back-to-back chained blocks and a reset in the middle of a run all be checked cycle by cycle.

// File: rtl/sha1_core_pkg.sv
package sha1_core_pkg;

  localparam int WORD_W      = 32;
  localparam int STATE_WORDS = 5;

  typedef logic [WORD_W-1:0] word_t;

  localparam logic [STATE_WORDS*WORD_W-1:0] INIT_VEC =
    160'h67452301_EFCDAB89_98BADCFE_10325476_C3D2E1F0;

  localparam word_t K_ROUND0 = 32'h5A827999;
  localparam word_t K_ROUND1 = 32'h6ED9EBA1;
  localparam word_t K_ROUND2 = 32'h8F1BBCDC;
  localparam word_t K_ROUND3 = 32'hCA62C1D6;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FOLD = 2'd2
  } ctrl_state_t;

  function automatic word_t rotl(input word_t x, input int n);
    return (x << n) | (x >> (WORD_W - n));
  endfunction

  function automatic word_t f_choose(input word_t b, input word_t c, input word_t d);
    return (b & c) | (~b & d);
  endfunction

  function automatic word_t f_parity(input word_t b, input word_t c, input word_t d);
    return b ^ c ^ d;
  endfunction

  function automatic word_t f_major(input word_t b, input word_t c, input word_t d);
    return (b & c) | (b & d) | (c & d);
  endfunction

endpackage

// File: rtl/sha1_round_fn.sv
module sha1_round_fn
  import sha1_core_pkg::*;
#(
  parameter int STEP_W          = 7,
  parameter int STEPS_PER_ROUND = 20
) (
  input  logic [STEP_W-1:0] step_idx,
  input  word_t             b_i,
  input  word_t             c_i,
  input  word_t             d_i,
  output word_t             f_o,
  output word_t             k_o
);

  localparam logic [STEP_W-1:0] EDGE1 = STEP_W'(STEPS_PER_ROUND);
  localparam logic [STEP_W-1:0] EDGE2 = STEP_W'(2 * STEPS_PER_ROUND);
  localparam logic [STEP_W-1:0] EDGE3 = STEP_W'(3 * STEPS_PER_ROUND);

  always_comb begin
    if (step_idx < EDGE1) begin
      f_o = f_choose(b_i, c_i, d_i);
      k_o = K_ROUND0;
    end else if (step_idx < EDGE2) begin
      f_o = f_parity(b_i, c_i, d_i);
      k_o = K_ROUND1;
    end else if (step_idx < EDGE3) begin
      f_o = f_major(b_i, c_i, d_i);
      k_o = K_ROUND2;
    end else begin
      f_o = f_parity(b_i, c_i, d_i);
      k_o = K_ROUND3;
    end
  end

endmodule

// File: rtl/sha1_msg_sched.sv
module sha1_msg_sched
  import sha1_core_pkg::*;
#(
  parameter int SCHED_WORDS = 16,
  parameter int STEP_W      = 7
) (
  input  logic                          clk,
  input  logic                          load_en,
  input  logic [SCHED_WORDS*WORD_W-1:0] block_i,
  input  logic                          step_en,
  input  logic [STEP_W-1:0]             step_idx,
  output word_t                         w_o
);

  localparam int IDX_W = $clog2(SCHED_WORDS);
  localparam logic [IDX_W-1:0] TAP_3  = IDX_W'(3);
  localparam logic [IDX_W-1:0] TAP_8  = IDX_W'(8);
  localparam logic [IDX_W-1:0] TAP_14 = IDX_W'(14);

  word_t ring      [SCHED_WORDS];
  word_t blk_words [SCHED_WORDS];

  genvar g;
  generate
    for (g = 0; g < SCHED_WORDS; g++) begin : g_unpack
      assign blk_words[g] = block_i[(SCHED_WORDS-1-g)*WORD_W +: WORD_W];
    end
  endgenerate

  logic [IDX_W-1:0] slot;
  logic             expand;
  word_t            w_mix;

  assign slot   = step_idx[IDX_W-1:0];
  assign expand = (step_idx >= STEP_W'(SCHED_WORDS));
  assign w_mix  = rotl(ring[slot - TAP_3] ^ ring[slot - TAP_8] ^
                       ring[slot - TAP_14] ^ ring[slot], 1);
  assign w_o    = expand ? w_mix : ring[slot];

  always_ff @(posedge clk) begin
    if (load_en) begin
      for (int i = 0; i < SCHED_WORDS; i++) ring[i] <= blk_words[i];
    end else if (step_en && expand) begin
      ring[slot] <= w_mix;
    end
  end

endmodule

// File: rtl/sha1_step_ctrl.sv
module sha1_step_ctrl
  import sha1_core_pkg::*;
#(
  parameter int NUM_STEPS = 80,
  parameter int STEP_W    = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  output logic              busy_o,
  output logic              accept_o,
  output logic              step_en_o,
  output logic              fold_o,
  output logic [STEP_W-1:0] step_idx_o
);

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

  ctrl_state_t state;

  assign accept_o  = start_i && (state == ST_IDLE);
  assign step_en_o = (state == ST_RUN);
  assign fold_o    = (state == ST_FOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      step_idx_o <= '0;
      busy_o     <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start_i) begin
            state      <= ST_RUN;
            step_idx_o <= '0;
            busy_o     <= 1'b1;
          end
        end
        ST_RUN: begin
          step_idx_o <= step_idx_o + 1'b1;
          if (step_idx_o == LAST_STEP) state <= ST_FOLD;
        end
        ST_FOLD: begin
          state  <= ST_IDLE;
          busy_o <= 1'b0;
        end
        default: begin
          state  <= ST_IDLE;
          busy_o <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/sha1_step_core.sv
module sha1_step_core
  import sha1_core_pkg::*;
#(
  parameter int NUM_STEPS       = 80,
  parameter int SCHED_WORDS     = 16,
  parameter int STEPS_PER_ROUND = 20
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          load_i,
  input  logic [SCHED_WORDS*WORD_W-1:0] block_i,
  input  logic                          start_i,
  input  logic                          use_iv_i,
  input  logic [STATE_WORDS*WORD_W-1:0] chain_i,
  output logic                          busy_o,
  output logic                          valid_o,
  output logic [STATE_WORDS*WORD_W-1:0] digest_o
);

  localparam int STEP_W  = $clog2(NUM_STEPS);
  localparam int CHAIN_W = STATE_WORDS * WORD_W;

  logic              accept;
  logic              step_en;
  logic              fold;
  logic [STEP_W-1:0] step_idx;
  word_t             w_cur;
  word_t             f_cur;
  word_t             k_cur;
  word_t             temp;

  word_t             wk      [STATE_WORDS];
  word_t             hin     [STATE_WORDS];
  word_t             chain_w [STATE_WORDS];
  logic [CHAIN_W-1:0] chain_sel;
  logic [CHAIN_W-1:0] digest_next;

  sha1_step_ctrl #(
    .NUM_STEPS (NUM_STEPS),
    .STEP_W    (STEP_W)
  ) ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .busy_o     (busy_o),
    .accept_o   (accept),
    .step_en_o  (step_en),
    .fold_o     (fold),
    .step_idx_o (step_idx)
  );

  sha1_msg_sched #(
    .SCHED_WORDS (SCHED_WORDS),
    .STEP_W      (STEP_W)
  ) sched_i (
    .clk      (clk),
    .load_en  (load_i && !busy_o),
    .block_i  (block_i),
    .step_en  (step_en),
    .step_idx (step_idx),
    .w_o      (w_cur)
  );

  sha1_round_fn #(
    .STEP_W          (STEP_W),
    .STEPS_PER_ROUND (STEPS_PER_ROUND)
  ) round_i (
    .step_idx (step_idx),
    .b_i      (wk[1]),
    .c_i      (wk[2]),
    .d_i      (wk[3]),
    .f_o      (f_cur),
    .k_o      (k_cur)
  );

  assign chain_sel = use_iv_i ? INIT_VEC : chain_i;
  assign temp      = rotl(wk[0], 5) + f_cur + wk[4] + w_cur + k_cur;

  genvar g;
  generate
    for (g = 0; g < STATE_WORDS; g++) begin : g_words
      assign chain_w[g] = chain_sel[(STATE_WORDS-1-g)*WORD_W +: WORD_W];
      assign digest_next[(STATE_WORDS-1-g)*WORD_W +: WORD_W] = wk[g] + hin[g];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STATE_WORDS; i++) begin
        wk[i]  <= '0;
        hin[i] <= '0;
      end
      digest_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (accept) begin
        for (int i = 0; i < STATE_WORDS; i++) begin
          wk[i]  <= chain_w[i];
          hin[i] <= chain_w[i];
        end
      end else if (step_en) begin
        wk[0] <= temp;
        wk[1] <= wk[0];
        wk[2] <= rotl(wk[1], 30);
        wk[3] <= wk[2];
        wk[4] <= wk[3];
      end
      if (fold) begin
        digest_o <= digest_next;
        valid_o  <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/sha1_step_core_chk.sv
module sha1_step_core_chk #(
  parameter int RUN_CYCLES = 81,
  parameter int DIG_W      = 160
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             busy_o,
  input logic             valid_o,
  input logic [DIG_W-1:0] digest_o
);

  int   busy_cnt;
  logic rst_seen;

  always_ff @(posedge clk) begin
    rst_seen <= rst;
    if (rst)         busy_cnt <= 0;
    else if (busy_o) busy_cnt <= busy_cnt + 1;
    else             busy_cnt <= 0;
  end

  // R9: outputs cleared after a reset edge
  always @(negedge clk) begin
    if (rst_seen === 1'b1) begin
      assert_reset_clears_R9: assert (!busy_o && !valid_o && digest_o == '0)
        else $error("reset left outputs non-zero");
    end
  end

  assert_start_busy_R3: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> busy_o);

  assert_busy_len_R4: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy_o) && !$past(rst)) |-> (busy_cnt == RUN_CYCLES));

  assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  assert_valid_at_done_R5: assert property (@(posedge clk) disable iff (rst)
    ($rose(valid_o) && !$past(rst)) |-> $fell(busy_o));

  assert_digest_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!valid_o && !$past(rst)) |-> $stable(digest_o));

endmodule

bind sha1_step_core sha1_step_core_chk #(
  .RUN_CYCLES (NUM_STEPS + 1),
  .DIG_W      (sha1_core_pkg::STATE_WORDS * sha1_core_pkg::WORD_W)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .valid_o  (valid_o),
  .digest_o (digest_o)
);

// File: tb/sha1_step_core_tb_top.sv
`timescale 1ns/1ps
module sha1_step_core_tb_top;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         load_i = 1'b0;
  logic [511:0] block_i = '0;
  logic         start_i = 1'b0;
  logic         use_iv_i = 1'b0;
  logic [159:0] chain_i = '0;
  logic         busy_o;
  logic         valid_o;
  logic [159:0] digest_o;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  sha1_step_core dut_i (
    .clk      (clk),
    .rst      (rst),
    .load_i   (load_i),
    .block_i  (block_i),
    .start_i  (start_i),
    .use_iv_i (use_iv_i),
    .chain_i  (chain_i),
    .busy_o   (busy_o),
    .valid_o  (valid_o),
    .digest_o (digest_o)
  );

  localparam logic [159:0] STD_IV  = 160'h67452301_EFCDAB89_98BADCFE_10325476_C3D2E1F0;
  localparam logic [511:0] BLK_ABC = {32'h61626380, 448'h0, 32'h00000018};
  localparam logic [511:0] BLK_LONG1 = {
    32'h61626364, 32'h62636465, 32'h63646566, 32'h64656667,
    32'h65666768, 32'h66676869, 32'h6768696a, 32'h68696a6b,
    32'h696a6b6c, 32'h6a6b6c6d, 32'h6b6c6d6e, 32'h6c6d6e6f,
    32'h6d6e6f70, 32'h6e6f7071, 32'h80000000, 32'h00000000};
  localparam logic [511:0] BLK_LONG2 = {480'h0, 32'h000001c0};

  function automatic logic [159:0] ref_compress(input logic [159:0] h, input logic [511:0] blk);
    int unsigned w [80];
    int unsigned a, b, c, d, e, f, k, x, tmp;
    for (int t = 0; t < 16; t++) w[t] = blk[511 - 32*t -: 32];
    for (int t = 16; t < 80; t++) begin
      x = w[t-3] ^ w[t-8] ^ w[t-14] ^ w[t-16];
      w[t] = (x << 1) | (x >> 31);
    end
    a = h[159:128]; b = h[127:96]; c = h[95:64]; d = h[63:32]; e = h[31:0];
    for (int t = 0; t < 80; t++) begin
      if (t < 20)      begin f = (b & c) | (~b & d);          k = 32'h5A827999; end
      else if (t < 40) begin f = b ^ c ^ d;                   k = 32'h6ED9EBA1; end
      else if (t < 60) begin f = (b & c) | (b & d) | (c & d); k = 32'h8F1BBCDC; end
      else             begin f = b ^ c ^ d;                   k = 32'hCA62C1D6; end
      tmp = ((a << 5) | (a >> 27)) + f + e + k + w[t];
      e = d; d = c; c = (b << 30) | (b >> 2); b = a; a = tmp;
    end
    a = a + h[159:128]; b = b + h[127:96]; c = c + h[95:64];
    d = d + h[63:32];   e = e + h[31:0];
    return {a, b, c, d, e};
  endfunction

  // Behavioural reference: a countdown of remaining busy cycles and a pending result
  int           left = 0;
  logic         m_busy = 1'b0;
  logic         m_valid = 1'b0;
  logic [159:0] m_dig = '0;
  logic [159:0] m_pend = '0;
  logic [511:0] m_blk = '0;

  always @(posedge clk) begin
    if (rst) begin
      left = 0; m_busy = 1'b0; m_valid = 1'b0; m_dig = '0;
    end else begin
      m_valid = 1'b0;
      if (left > 0) begin
        left = left - 1;
        if (left == 0) begin
          m_busy = 1'b0; m_valid = 1'b1; m_dig = m_pend;
        end
      end else begin
        if (load_i) m_blk = block_i;
        if (start_i) begin
          m_pend = ref_compress(use_iv_i ? STD_IV : chain_i, m_blk);
          left = 81;
          m_busy = 1'b1;
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [159:0] act, input logic [159:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  bit compare_on = 1'b0;
  always @(negedge clk) begin
    if (compare_on) begin
      check(busy_o == m_busy, "R3/R4 busy_o vs model", {159'h0, busy_o}, {159'h0, m_busy});
      check(valid_o == m_valid, "R5 valid_o vs model", {159'h0, valid_o}, {159'h0, m_valid});
      check(digest_o == m_dig, "R2/R5 digest_o vs model", digest_o, m_dig);
    end
  end

  task automatic pulse(input bit ld, input bit st, input bit iv, input logic [511:0] blk, input logic [159:0] cv);
    load_i = ld; start_i = st; use_iv_i = iv; block_i = blk; chain_i = cv;
    @(negedge clk);
    load_i = 1'b0; start_i = 1'b0;
  endtask

  task automatic wait_valid(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 200 && !seen; i++) begin
      if (valid_o) seen = 1'b1;
      else @(negedge clk);
    end
  endtask

  initial begin
    bit seen;
    logic [159:0] h1;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(!busy_o && !valid_o && digest_o == '0, "R9 reset state", digest_o, '0);
    rst = 1'b0;
    compare_on = 1'b1;
    @(negedge clk);

    // R1, R7, R8: load and start together, standard IV, "abc"
    pulse(1, 1, 1, BLK_ABC, '0);
    check(busy_o, "R3 busy after start", {159'h0, busy_o}, 160'h1);
    wait_valid(seen);
    check(seen, "R5 valid seen", {159'h0, seen}, 160'h1);
    check(digest_o == 160'ha9993e364706816aba3e25717850c26c9cd0d89d, "R1 R7 R8 abc digest",
          digest_o, 160'ha9993e364706816aba3e25717850c26c9cd0d89d);
    @(negedge clk);
    check(!valid_o, "R5 valid single cycle", {159'h0, valid_o}, '0);

    // R6, R2: separate load then start; then chain a second block
    pulse(1, 0, 0, BLK_LONG1, '0);
    pulse(0, 1, 1, '0, '0);
    wait_valid(seen);
    h1 = digest_o;
    pulse(1, 1, 0, BLK_LONG2, h1);
    wait_valid(seen);
    check(digest_o == 160'h84983e441c3bd26ebaae4aa1f95129e5e54670f1, "R2 chained two-block digest",
          digest_o, 160'h84983e441c3bd26ebaae4aa1f95129e5e54670f1);
    @(negedge clk);

    // R3, R6: start and load during a run are ignored
    pulse(1, 1, 0, BLK_ABC, 160'h0123456789abcdef_fedcba98_76543210_deadbeef);
    repeat (10) @(negedge clk);
    pulse(1, 1, 1, {16{32'hffff0000}}, STD_IV);
    repeat (20) @(negedge clk);
    pulse(1, 0, 0, {16{32'h5a5a5a5a}}, '0);
    wait_valid(seen);
    check(digest_o == ref_compress(160'h0123456789abcdef_fedcba98_76543210_deadbeef, BLK_ABC),
          "R3 R6 ignored pulses while busy", digest_o,
          ref_compress(160'h0123456789abcdef_fedcba98_76543210_deadbeef, BLK_ABC));
    // back-to-back start in the valid cycle is accepted (busy already low)
    pulse(1, 1, 1, {16{32'h13579bdf}}, '0);
    check(busy_o, "R3 restart in valid cycle", {159'h0, busy_o}, 160'h1);
    wait_valid(seen);
    check(seen, "R4 second run completes", {159'h0, seen}, 160'h1);

    // R9: reset in the middle of a run
    pulse(1, 1, 1, BLK_ABC, '0);
    repeat (30) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(!busy_o && !valid_o && digest_o == '0, "R9 mid-run reset clears", digest_o, '0);
    rst = 1'b0;
    repeat (120) @(negedge clk);
    check(!valid_o && !busy_o, "R9 abandoned run stays silent", {158'h0, busy_o, valid_o}, '0);
    pulse(1, 1, 1, BLK_ABC, '0);
    wait_valid(seen);
    check(digest_o == 160'ha9993e364706816aba3e25717850c26c9cd0d89d, "R1 R9 run after reset",
          digest_o, 160'ha9993e364706816aba3e25717850c26c9cd0d89d);
    repeat (3) @(negedge clk);

    compare_on = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule